// File: doc/BRIEF.md
# Signal Measurement Timer with Captures

This block measures the timing of a digital signal by counting timer ticks. A 24-bit up-counter advances on a selectable tick source: either every system clock, or a chosen edge of an external timer clock pin. A window input can gate the count, and the signal input drives two captures. A rising edge of the conditioned signal stores the running count as the period and restarts the count from zero. A falling edge stores the running count as the pulse width. A period register sets a match point. On a match the counter either wraps to zero or, in limit mode, holds at the period value.

Software drives the block through a small register port. It sets the control bits and starts the timer with a go bit, issues one-shot commands, and reads counts, captures, sticky flags and synchronized status. In single-acquisition mode, the go bit drops by itself at the first period capture. In repeat mode the timer runs until software stops it. A match also produces a one-clock pulse on a dedicated output. Every external pin passes through a two-flop synchronizer before it is used.

The block moves no stream data, so there is no back-pressure. Register reads return one cycle after the request, flagged by `rd_valid`. Every read is accepted, and the consumer must take the data in that cycle.

Top module: `smt_meas_timer`

## Requirements
- R1: After reset the registers read as follows: CTRL (addr 0) = 0, PERIOD (addr 2) = 0xFFFFFF, COUNT (addr 3) = 0, PWCAP (addr 4) = 0, PERCAP (addr 5) = 0 and FLAGS (addr 6) = 0. The match pulse and all three interrupt outputs are low.
- R2: In internal tick mode (CTRL bit 3 = 0), COUNT rises by one on every clock edge for which CTRL bit 0 (go) was high beforehand. With go low, COUNT holds.
- R3: With CTRL bit 3 = 1, the tick is an edge of the synchronized `tclk_in`. Rising edges count when CTRL bit 4 = 0, and falling edges count when CTRL bit 4 = 1.
- R4: A tick that finds COUNT equal to PERIOD with limit off (CTRL bit 2 = 0) returns COUNT to 0. It also raises `match_pulse` for exactly one clock and sets FLAGS bit 2.
- R5: With limit on, a tick at COUNT == PERIOD leaves COUNT at PERIOD while go stays high, and FLAGS bit 3 (run) reads 1.
- R6: While running, a rising edge of the conditioned signal copies COUNT into PERCAP, clears COUNT and sets FLAGS bit 1. The conditioned signal is `sig_in` XOR CTRL bit 5. Because the edge cycle is not counted, PERCAP is one less than the number of clocks between two rising edges in internal mode.
- R7: While running, a falling edge of the conditioned signal copies COUNT into PWCAP and sets FLAGS bit 0. In internal mode, PWCAP is one less than the high time in clocks.
- R8: With CTRL bit 7 = 1, ticks count only while the synchronized window (`win_in` XOR CTRL bit 6) is high. The number of ticks equals the number of clocks the window was active.
- R9: With CTRL bit 1 (repeat) = 0, go clears at the period capture and signal edges after that are ignored.
- R10: Writing CMD (addr 1) bit 1 loads PWCAP from COUNT and sets FLAGS bit 0. Writing CMD bit 2 loads PERCAP from COUNT and sets FLAGS bit 1. Either command works while stopped.
- R11: Writing CMD bit 0 clears COUNT in one cycle. A clear takes priority over every other counter update.
- R12: FLAGS bits 0 to 2 stay set until a write of 1 to that bit. Writing 0 to a bit leaves it unchanged. `irq_pw`, `irq_pr` and `irq_match` mirror these bits.
- R13: FLAGS bit 4 reads the conditioned signal and FLAGS bit 5 reads the conditioned window, both after the two-flop synchronizer.
- R14: A read request returns `rd_valid` high with the data one cycle later. Unmapped addresses and CMD read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tclk_in | input | 1 | External timer clock pin |
| sig_in | input | 1 | Measured signal pin |
| win_in | input | 1 | Window pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 24 | Write data |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 3 | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after request |
| rd_data | output | 24 | Read data |
| match_pulse | output | 1 | One-clock pulse per period match |
| irq_pw | output | 1 | Pulse-width capture flag |
| irq_pr | output | 1 | Period capture flag |
| irq_match | output | 1 | Period match flag |

## Verification
The embedded assertions check the counter's step rules on every cycle: increment, hold, wrap at the period, hold in limit mode and clear priority. They also check that each capture loads the previous count and sets its flag, that flags are sticky, and that single-acquisition mode stops. The bench scenarios are needed for the things that depend on pin timing through the synchronizers: edge and polarity selection of the external tick, the window count, and the measured width and period values. The same applies to pulse counts over a run and to reset values seen from the read port.

// File: rtl/smt_pkg.sv
`timescale 1ns/1ps
package smt_pkg;
  localparam int AW = 3;

  localparam logic [AW-1:0] ADR_CTRL   = 3'd0;
  localparam logic [AW-1:0] ADR_CMD    = 3'd1;
  localparam logic [AW-1:0] ADR_PERIOD = 3'd2;
  localparam logic [AW-1:0] ADR_COUNT  = 3'd3;
  localparam logic [AW-1:0] ADR_PWCAP  = 3'd4;
  localparam logic [AW-1:0] ADR_PRCAP  = 3'd5;
  localparam logic [AW-1:0] ADR_FLAGS  = 3'd6;

  localparam int CMD_CLR = 0;
  localparam int CMD_PW  = 1;
  localparam int CMD_PR  = 2;

  localparam int NFLAG = 3;
  localparam int FL_PW    = 0;
  localparam int FL_PR    = 1;
  localparam int FL_MATCH = 2;

  typedef struct packed {
    logic win_gate;
    logic win_pol;
    logic sig_pol;
    logic clk_pol;
    logic clk_sel;
    logic limit;
    logic rpt;
    logic go;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/smt_sync.sv
`timescale 1ns/1ps
module smt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  logic [W-1:0] pipe [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q   = pipe[STAGES-1];
  assign q_d = pipe[STAGES];
endmodule

// File: rtl/smt_counter.sv
`timescale 1ns/1ps
module smt_counter #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  input  logic          restart,
  input  logic          limit,
  input  logic [DW-1:0] period,
  output logic [DW-1:0] count,
  output logic          match,
  output logic          match_q
);
  logic at_period;
  assign at_period = (count == period);
  assign match     = tick & at_period & ~clr & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= match;
      if (clr)                count <= '0;
      else if (restart)       count <= '0;
      else if (tick) begin
        if (at_period) begin
          if (!limit) count <= '0;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && !restart && count != period) |=> count == DW'($past(count) + 1'b1)); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr && !restart) |=> $stable(count)); // R2
  AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && !restart && !limit && count == period) |=> count == '0); // R4
  AST_LIMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && !restart && limit && count == period) |=> count == $past(count)); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0); // R11
endmodule

// File: rtl/smt_capture.sv
`timescale 1ns/1ps
module smt_capture
  import smt_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    count,
  input  logic             pw_evt,
  input  logic             pr_evt,
  input  logic             match_evt,
  input  logic [NFLAG-1:0] flag_clr,
  output logic [DW-1:0]    cpw,
  output logic [DW-1:0]    cpr,
  output logic [NFLAG-1:0] flags
);
  logic [NFLAG-1:0] flag_set;
  assign flag_set[FL_PW]    = pw_evt;
  assign flag_set[FL_PR]    = pr_evt;
  assign flag_set[FL_MATCH] = match_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpw <= '0;
      cpr <= '0;
    end else begin
      if (pw_evt) cpw <= count;
      if (pr_evt) cpr <= count;
    end
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[g] <= 1'b0;
      else        flags[g] <= (flags[g] & ~flag_clr[g]) | flag_set[g];
    end
  end

  AST_PR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pr_evt |=> (cpr == $past(count) && flags[FL_PR])); // R6
  AST_PW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pw_evt |=> (cpw == $past(count) && flags[FL_PW])); // R7
  AST_MATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FL_MATCH] && !flag_clr[FL_MATCH]) |=> flags[FL_MATCH]); // R12
  AST_PR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FL_PR] && !flag_clr[FL_PR]) |=> flags[FL_PR]); // R12
endmodule

// File: rtl/smt_regs.sv
`timescale 1ns/1ps
module smt_regs
  import smt_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic             acq_done,
  input  logic [DW-1:0]    count,
  input  logic [DW-1:0]    cpw,
  input  logic [DW-1:0]    cpr,
  input  logic [NFLAG-1:0] flags,
  input  logic             sig_st,
  input  logic             win_st,
  output ctrl_t            ctrl,
  output logic [DW-1:0]    period,
  output logic             cmd_clr,
  output logic             cmd_pw,
  output logic             cmd_pr,
  output logic [NFLAG-1:0] flag_clr,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data
);
  logic ctrl_wr, cmd_wr, per_wr, flg_wr;
  assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);
  assign cmd_wr  = wr_en && (wr_addr == ADR_CMD);
  assign per_wr  = wr_en && (wr_addr == ADR_PERIOD);
  assign flg_wr  = wr_en && (wr_addr == ADR_FLAGS);

  assign cmd_clr  = cmd_wr && wr_data[CMD_CLR];
  assign cmd_pw   = cmd_wr && wr_data[CMD_PW];
  assign cmd_pr   = cmd_wr && wr_data[CMD_PR];
  assign flag_clr = flg_wr ? wr_data[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      period <= '1;
    end else begin
      if (ctrl_wr)                   ctrl   <= ctrl_t'(wr_data[CTRL_W-1:0]);
      else if (acq_done && !ctrl.rpt) ctrl.go <= 1'b0;
      if (per_wr) period <= wr_data;
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    case (rd_addr)
      ADR_CTRL:   rd_mux = DW'(ctrl);
      ADR_PERIOD: rd_mux = period;
      ADR_COUNT:  rd_mux = count;
      ADR_PWCAP:  rd_mux = cpw;
      ADR_PRCAP:  rd_mux = cpr;
      ADR_FLAGS:  rd_mux = DW'({win_st, sig_st, ctrl.go, flags});
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_done && !ctrl.rpt && !ctrl_wr) |=> !ctrl.go); // R9
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en)); // R14
endmodule

// File: rtl/smt_meas_timer.sv
`timescale 1ns/1ps
module smt_meas_timer
  import smt_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tclk_in,
  input  logic          sig_in,
  input  logic          win_in,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [2:0]    rd_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          match_pulse,
  output logic          irq_pw,
  output logic          irq_pr,
  output logic          irq_match
);
  localparam int NPIN = 3;

  ctrl_t            ctrl;
  logic [DW-1:0]    period, count, cpw, cpr;
  logic [NFLAG-1:0] flags, flag_clr;
  logic             cmd_clr, cmd_pw, cmd_pr;
  logic [NPIN-1:0]  pin_q, pin_qd;
  logic             match;

  smt_sync #(.W(NPIN), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({win_in, sig_in, tclk_in}),
    .q(pin_q), .q_d(pin_qd)
  );

  logic t_now, t_prev, s_now, s_prev, w_now;
  assign t_now  = pin_q[0]  ^ ctrl.clk_pol;
  assign t_prev = pin_qd[0] ^ ctrl.clk_pol;
  assign s_now  = pin_q[1]  ^ ctrl.sig_pol;
  assign s_prev = pin_qd[1] ^ ctrl.sig_pol;
  assign w_now  = pin_q[2]  ^ ctrl.win_pol;

  logic tick_src, win_ok, tick, sig_rise, sig_fall;
  assign tick_src = ctrl.clk_sel ? (t_now & ~t_prev) : 1'b1;
  assign win_ok   = ctrl.win_gate ? w_now : 1'b1;
  assign tick     = ctrl.go & tick_src & win_ok;
  assign sig_rise = ctrl.go & s_now & ~s_prev;
  assign sig_fall = ctrl.go & ~s_now & s_prev;

  smt_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .tick(tick), .clr(cmd_clr), .restart(sig_rise),
    .limit(ctrl.limit), .period(period),
    .count(count), .match(match), .match_q(match_pulse)
  );

  smt_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .count(count),
    .pw_evt(sig_fall | cmd_pw), .pr_evt(sig_rise | cmd_pr),
    .match_evt(match), .flag_clr(flag_clr),
    .cpw(cpw), .cpr(cpr), .flags(flags)
  );

  smt_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .acq_done(sig_rise),
    .count(count), .cpw(cpw), .cpr(cpr), .flags(flags),
    .sig_st(s_now), .win_st(w_now),
    .ctrl(ctrl), .period(period),
    .cmd_clr(cmd_clr), .cmd_pw(cmd_pw), .cmd_pr(cmd_pr),
    .flag_clr(flag_clr),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign irq_pw    = flags[FL_PW];
  assign irq_pr    = flags[FL_PR];
  assign irq_match = flags[FL_MATCH];

  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> irq_match); // R4
  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.go && !cmd_clr) |=> $stable(count)); // R2
endmodule

// File: tb/tb_smt_meas_timer.sv
`timescale 1ns/1ps
module tb_smt_meas_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tclk_in, sig_in, win_in;
  logic        wr_en, rd_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [23:0] wr_data;
  logic        rd_valid;
  logic [23:0] rd_data;
  logic        match_pulse, irq_pw, irq_pr, irq_match;

  always #2.5 clk = ~clk;

  smt_meas_timer dut (
    .clk(clk), .rst_n(rst_n), .tclk_in(tclk_in), .sig_in(sig_in), .win_in(win_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .match_pulse(match_pulse), .irq_pw(irq_pw), .irq_pr(irq_pr), .irq_match(irq_match)
  );

  int          n_vec = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;
  logic [23:0] exp_q[$];
  string       tag_q[$];

  bit pc_en = 1'b0;
  int pc_cnt = 0;
  int pc_dbl = 0;
  bit pc_prev = 1'b0;

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [23:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [23:0] e, string tag);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R14 unexpected rd_valid", 24'd1, 24'd0);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
    if (pc_en) begin
      if (match_pulse) pc_cnt++;
      if (match_pulse && pc_prev) pc_dbl++;
      pc_prev = match_pulse;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tclk_in = 0; sig_in = 0; win_in = 0;
    wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state, R14 unmapped and CMD reads
    check("R1 match_pulse", 24'(match_pulse), 24'd0);
    check("R1 irqs", 24'({irq_pw, irq_pr, irq_match}), 24'd0);
    rd(3'd0, 24'h0, "R1 CTRL");
    rd(3'd2, 24'hFFFFFF, "R1 PERIOD");
    rd(3'd3, 24'h0, "R1 COUNT");
    rd(3'd4, 24'h0, "R1 PWCAP");
    rd(3'd5, 24'h0, "R1 PERCAP");
    rd(3'd6, 24'h0, "R1 FLAGS");
    rd(3'd7, 24'h0, "R14 unmapped");
    rd(3'd1, 24'h0, "R14 CMD reads zero");

    // R2 internal counting: ticks = idle + 1
    wr(3'd0, 24'h01);
    idle(9);
    wr(3'd0, 24'h00);
    rd(3'd3, 24'd10, "R2 count after run");
    idle(5);
    rd(3'd3, 24'd10, "R2 count holds stopped");

    // R10 manual captures, R12 flags, R11 clear
    wr(3'd1, 24'h2);
    wr(3'd1, 24'h4);
    rd(3'd4, 24'd10, "R10 PWCAP cmd");
    rd(3'd5, 24'd10, "R10 PERCAP cmd");
    rd(3'd6, 24'h3, "R10 flags set");
    check("R12 irq_pw", 24'(irq_pw), 24'd1);
    wr(3'd6, 24'h0);
    rd(3'd6, 24'h3, "R12 zero write keeps");
    wr(3'd6, 24'h1);
    rd(3'd6, 24'h2, "R12 clear bit0");
    wr(3'd6, 24'h2);
    rd(3'd6, 24'h0, "R12 clear bit1");
    wr(3'd1, 24'h1);
    rd(3'd3, 24'd0, "R11 clear cmd");

    // R4 period match, wrap, one-clock pulse
    wr(3'd2, 24'd4);
    pc_cnt = 0; pc_dbl = 0; pc_prev = 0; pc_en = 1'b1;
    wr(3'd0, 24'h03);
    idle(22);
    wr(3'd0, 24'h00);
    idle(3);
    pc_en = 1'b0;
    check("R4 pulse count", 24'(pc_cnt), 24'd4);
    check("R4 pulse one clock", 24'(pc_dbl), 24'd0);
    rd(3'd3, 24'd3, "R4 count after wraps");
    rd(3'd6, 24'h4, "R4 match flag");
    check("R4 irq_match", 24'(irq_match), 24'd1);
    wr(3'd6, 24'h4);
    wr(3'd1, 24'h1);

    // R5 limit mode
    wr(3'd2, 24'd6);
    wr(3'd0, 24'h05);
    idle(10);
    rd(3'd6, 24'hC, "R5 running with match");
    wr(3'd0, 24'h00);
    rd(3'd3, 24'd6, "R5 count held at period");
    wr(3'd6, 24'h4);
    wr(3'd1, 24'h1);

    // R6 R7 signal measurement, repeat mode
    wr(3'd2, 24'hFFFFFF);
    wr(3'd0, 24'h03);
    idle(3);
    sig_in = 1; idle(7);
    sig_in = 0; idle(12);
    sig_in = 1; idle(6);
    rd(3'd6, 24'd27, "R13 status sig high running");
    wr(3'd0, 24'h00);
    rd(3'd4, 24'd6, "R7 pulse width");
    rd(3'd5, 24'd18, "R6 period");
    sig_in = 0; idle(4);
    wr(3'd6, 24'h3);

    // R6 signal polarity
    wr(3'd0, 24'h20);
    sig_in = 1; idle(4);
    rd(3'd6, 24'h0, "R13 inverted sig status");
    wr(3'd0, 24'h23);
    idle(3);
    sig_in = 0; idle(5);
    sig_in = 1; idle(7);
    sig_in = 0; idle(5);
    wr(3'd0, 24'h20);
    rd(3'd4, 24'd4, "R7 inverted width");
    rd(3'd5, 24'd11, "R6 inverted period");
    wr(3'd0, 24'h00);
    idle(4);
    wr(3'd6, 24'h3);
    wr(3'd1, 24'h1);

    // R9 single acquisition
    wr(3'd0, 24'h01);
    idle(5);
    sig_in = 1; idle(6);
    rd(3'd0, 24'h0, "R9 go cleared");
    rd(3'd3, 24'd0, "R9 count restarted");
    rd(3'd5, 24'd7, "R9 period captured");
    sig_in = 0; idle(5);
    sig_in = 1; idle(6);
    rd(3'd5, 24'd7, "R9 later edge ignored");
    rd(3'd6, 24'd18, "R9 flags after stop");
    sig_in = 0; idle(4);
    wr(3'd6, 24'h3);

    // R8 window gating
    wr(3'd0, 24'h83);
    idle(6);
    rd(3'd3, 24'd0, "R8 no window no count");
    win_in = 1; idle(9);
    win_in = 0; idle(4);
    rd(3'd3, 24'd9, "R8 window count");
    rd(3'd6, 24'h8, "R13 run status window low");
    wr(3'd0, 24'h00);
    wr(3'd1, 24'h1);
    win_in = 1; idle(4);
    wr(3'd0, 24'hC3);
    idle(8);
    rd(3'd3, 24'd0, "R8 inverted window blocks");
    rd(3'd6, 24'h8, "R13 inverted window status");
    wr(3'd0, 24'h00);
    win_in = 0; idle(4);
    wr(3'd1, 24'h1);

    // R3 external timer clock, rising then falling edge select
    wr(3'd0, 24'h0B);
    idle(3);
    for (int i = 0; i < 9; i++) begin
      tclk_in = ~tclk_in; idle(2);
    end
    idle(4);
    wr(3'd0, 24'h00);
    rd(3'd3, 24'd5, "R3 rising edges counted");
    wr(3'd1, 24'h1);
    wr(3'd0, 24'h1B);
    idle(3);
    for (int i = 0; i < 7; i++) begin
      tclk_in = ~tclk_in; idle(2);
    end
    idle(4);
    wr(3'd0, 24'h00);
    rd(3'd3, 24'd4, "R3 falling edges counted");

    idle(3);
    finish_run();
  end
endmodule